// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block turns one block load/store request into a sequence of single-word memory accesses. The request gives a base address, a register mask with one bit per architectural register, an addressing mode, a direction (load or store) and a writeback flag. The block then issues one access per clock cycle. Each access carries the register index, the word address and the direction.

Registers are always visited from the lowest index to the highest, and the lowest index always uses the lowest address. The mode only decides where that lowest address lies relative to the base: upward or downward, and stepping before or after the first word. After the last access, a one-cycle completion pulse carries the updated base for writeback. The same pulse carries a flag that is set when the program counter (the highest register index) was among the loaded registers.

The surrounding pipeline supplies the memory and register file. It holds the start request until the sequencer is idle.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o, acc_valid_o, done_o, wb_valid_o and pc_load_o are all low.
- R2: A request with N set mask bits gives exactly N accesses on N consecutive cycles, starting the cycle after start_i is sampled. The register indices go out in strictly ascending order.
- R3: Mode 0 (ascending, step after) starts at the base address.
- R4: Mode 1 (ascending, step before) starts at base + 4.
- R5: Mode 2 (descending, step after) starts at base - 4N + 4.
- R6: Mode 3 (descending, step before) starts at base - 4N.
- R7: Within one request, each access address is 4 above the address of the previous access.
- R8: wb_base_o is base + 4N for modes 0 and 1 and base - 4N for modes 2 and 3. It is valid in the done cycle. wb_valid_o is high only in the done cycle, and only when the writeback flag was set.
- R9: done_o is high for exactly one cycle, the cycle after the last access, and no access is valid in that cycle.
- R10: An empty mask produces no access, and done_o is high in the cycle after start_i is sampled.
- R11: While busy_o is high, start_i is ignored. The running sequence of indices and addresses is unchanged.
- R12: pc_load_o rises with done_o only when the request was a load and mask bit NREG-1 was set.
- R13: acc_load_o, while acc_valid_o is high, equals the load select captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| base_i | input | ADDR_W | Base address |
| list_i | input | NREG | Register mask, bit i selects register i |
| mode_i | input | 2 | 0 up/after, 1 up/before, 2 down/after, 3 down/before |
| load_i | input | 1 | 1 load, 0 store |
| wb_en_i | input | 1 | Request base writeback |
| busy_o | output | 1 | Sequence in progress |
| acc_valid_o | output | 1 | Access issued this cycle |
| acc_idx_o | output | $clog2(NREG) | Register index of the access |
| acc_addr_o | output | ADDR_W | Word address of the access |
| acc_load_o | output | 1 | Access direction, 1 = load |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Write wb_base_o into the base register |
| wb_base_o | output | ADDR_W | Updated base value |
| pc_load_o | output | 1 | Program counter was loaded |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-entry mask and 4-byte words. With a 16-entry mask, the full mask reaches the largest span (64 bytes) and the longest sequence. It also reaches the top index, which serves as the program counter flag. The 32-bit address allows the descending modes to be exercised from bases where base - 4N stays in range. A mask with gaps, the empty mask and a start pulse in the middle of a sequence cover the encoder skipping and the idle gating.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    MODE_UP_AFTER   = 2'd0,
    MODE_UP_BEFORE  = 2'd1,
    MODE_DN_AFTER   = 2'd2,
    MODE_DN_BEFORE  = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/xfer_popcount.sv
module xfer_popcount #(
  parameter int NREG  = 16,
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/xfer_prio_enc.sv
module xfer_prio_enc #(
  parameter int NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // Scan high to low so the lowest set bit wins.
  always_comb begin
    idx_o = '0;
    any_o = |vec_i;
    for (int i = NREG - 1; i >= 0; i--) if (vec_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/xfer_addr_calc.sv
module xfer_addr_calc
  import xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] final_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  xfer_mode_e        mode;

  assign span = ADDR_W'(cnt_i) * STEP;
  assign mode = xfer_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_UP_AFTER:  first_o = base_i;
      MODE_UP_BEFORE: first_o = base_i + STEP;
      MODE_DN_AFTER:  first_o = base_i - span + STEP;
      default:        first_o = base_i - span;
    endcase
    final_o = mode_i[1] ? (base_i - span) : (base_i + span);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   list_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic              wb_en_i,
  output logic              busy_o,
  output logic              acc_valid_o,
  output logic [IDX_W-1:0]  acc_idx_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_load_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              pc_load_o
);
  localparam int PC_IDX = NREG - 1;

  logic              busy_q, done_q, load_q, wb_q, pc_q;
  logic [NREG-1:0]   pend_q, pend_next;
  logic [ADDR_W-1:0] addr_q, wb_base_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] first_addr, final_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic              pend_any;

  xfer_popcount #(.NREG(NREG)) u_cnt (.vec_i(list_i), .cnt_o(cnt));

  xfer_addr_calc #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base_i(base_i), .cnt_i(cnt), .mode_i(mode_i),
    .first_o(first_addr), .final_o(final_addr)
  );

  xfer_prio_enc #(.NREG(NREG)) u_enc (.vec_i(pend_q), .idx_o(cur_idx), .any_o(pend_any));

  // Drop the lowest pending bit.
  assign pend_next = pend_q & (pend_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      load_q    <= 1'b0;
      wb_q      <= 1'b0;
      pc_q      <= 1'b0;
      pend_q    <= '0;
      addr_q    <= '0;
      wb_base_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          load_q    <= load_i;
          wb_q      <= wb_en_i;
          pc_q      <= load_i & list_i[PC_IDX];
          wb_base_q <= final_addr;
          if (list_i == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            pend_q <= list_i;
            addr_q <= first_addr;
          end
        end
      end else begin
        pend_q <= pend_next;
        addr_q <= addr_q + ADDR_W'(WORD_BYTES);
        if (pend_next == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign acc_valid_o = busy_q & pend_any;
  assign acc_idx_o   = cur_idx;
  assign acc_addr_o  = addr_q;
  assign acc_load_o  = load_q;
  assign done_o      = done_q;
  assign wb_valid_o  = done_q & wb_q;
  assign wb_base_o   = wb_base_q;
  assign pc_load_o   = done_q & pc_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              acc_valid_o,
  input logic [IDX_W-1:0]  acc_idx_o,
  input logic [ADDR_W-1:0] acc_addr_o,
  input logic              done_o,
  input logic              wb_valid_o,
  input logic              pc_load_o
);
  AST_VALID_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> busy_o); // R2

  AST_IDX_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && $past(acc_valid_o) && $past(busy_o) && busy_o)
      |-> acc_idx_o > $past(acc_idx_o)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_o && $past(acc_valid_o) && $past(busy_o) && busy_o)
      |-> acc_addr_o == $past(acc_addr_o) + ADDR_W'(WORD_BYTES)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_NO_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !acc_valid_o); // R9

  AST_WB_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o); // R8

  AST_PC_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> done_o); // R12

  AST_START_HELD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && acc_valid_o) |=> (busy_o || done_o)); // R11
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
  .ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .acc_valid_o(acc_valid_o), .acc_idx_o(acc_idx_o), .acc_addr_o(acc_addr_o),
  .done_o(done_o), .wb_valid_o(wb_valid_o), .pc_load_o(pc_load_o)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int ADDR_W = 32;
  localparam int NREG   = 16;
  localparam int IDX_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] base_i = '0;
  logic [NREG-1:0]   list_i = '0;
  logic [1:0]        mode_i = '0;
  logic              load_i = 1'b0;
  logic              wb_en_i = 1'b0;
  logic              busy_o, acc_valid_o, acc_load_o, done_o, wb_valid_o, pc_load_o;
  logic [IDX_W-1:0]  acc_idx_o;
  logic [ADDR_W-1:0] acc_addr_o, wb_base_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  blk_xfer_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .list_i(list_i), .mode_i(mode_i), .load_i(load_i), .wb_en_i(wb_en_i),
    .busy_o(busy_o), .acc_valid_o(acc_valid_o), .acc_idx_o(acc_idx_o),
    .acc_addr_o(acc_addr_o), .acc_load_o(acc_load_o), .done_o(done_o),
    .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o), .pc_load_o(pc_load_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Generic runner; intrude=1 pulses a conflicting start mid-sequence (R11).
  task automatic run_xfer(input string req, input logic [31:0] base,
                          input logic [15:0] lst, input logic [1:0] mode,
                          input bit ld, input bit wb, input bit intrude);
    int n, k, cyc, idx_q[$];
    logic [31:0] lo, wbx;
    n = $countones(lst);
    for (int i = 0; i < NREG; i++) if (lst[i]) idx_q.push_back(i);
    case (mode)
      2'd0: lo = base;
      2'd1: lo = base + 32'd4;
      2'd2: lo = base - 32'(4 * n) + 32'd4;
      default: lo = base - 32'(4 * n);
    endcase
    wbx = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    @(negedge clk_i);
    start_i = 1'b1; base_i = base; list_i = lst; mode_i = mode; load_i = ld; wb_en_i = wb;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0; cyc = 0;
    while (!done_o && cyc < 40) begin
      if (acc_valid_o) begin
        if (k < n) begin
          chk(acc_idx_o == IDX_W'(idx_q[k]), "R2", {req, " index"}, 32'(acc_idx_o), 32'(idx_q[k]));
          chk(acc_addr_o == lo + 32'(4 * k), k == 0 ? req : "R7", "address",
              acc_addr_o, lo + 32'(4 * k));
          chk(acc_load_o == ld, "R13", "direction", 32'(acc_load_o), 32'(ld));
        end
        k++;
      end
      if (intrude && cyc == 1) begin
        start_i = 1'b1; base_i = 32'hDEAD_0000; list_i = 16'h8000; mode_i = 2'd3; load_i = ~ld;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    chk(k == n, "R2", {req, " access count"}, 32'(k), 32'(n));
    chk(cyc == n, n == 0 ? "R10" : "R9", "done cycle", 32'(cyc), 32'(n));
    chk(done_o && !acc_valid_o, "R9", "done without access", 32'(acc_valid_o), 32'd0);
    chk(wb_valid_o == wb, "R8", "wb_valid", 32'(wb_valid_o), 32'(wb));
    chk(wb_base_o == wbx, "R8", "wb_base", wb_base_o, wbx);
    chk(pc_load_o == (ld && lst[15]), "R12", "pc_load", 32'(pc_load_o), 32'(ld && lst[15]));
    @(negedge clk_i);
    chk(!done_o && !wb_valid_o && !pc_load_o, "R9", "done one cycle", 32'(done_o), 32'd0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !acc_valid_o && !done_o && !wb_valid_o && !pc_load_o,
        "R1", "reset outputs", {27'd0, busy_o, acc_valid_o, done_o, wb_valid_o, pc_load_o}, 32'd0);
  endtask
  task automatic t_up_after();   run_xfer("R3", 32'h1000, 16'h0023, 2'd0, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_up_before();  run_xfer("R4", 32'h2000, 16'h00F0, 2'd1, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_dn_after();   run_xfer("R5", 32'h3000, 16'h8421, 2'd2, 1'b1, 1'b1, 1'b0); endtask
  task automatic t_dn_before();  run_xfer("R6", 32'h4000, 16'hFFFF, 2'd3, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_empty();      run_xfer("R10", 32'h5000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0); endtask
  task automatic t_busy_start(); run_xfer("R11", 32'h6000, 16'h0107, 2'd0, 1'b1, 1'b0, 1'b1); endtask
  task automatic t_store_pc();   run_xfer("R12", 32'h7000, 16'h8001, 2'd1, 1'b0, 1'b0, 1'b0); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_up_after();
    t_up_before();
    t_dn_after();
    t_dn_before();
    t_empty();
    t_busy_start();
    t_store_pc();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule